// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

The block converts one pointer event into a five-byte serial mouse packet and places those bytes into a small receive queue. The event arrives as a single-cycle strobe. It carries signed horizontal and vertical motion and the state of three buttons. The block encodes the buttons as active-low bits in a header byte and clamps both motion values to a symmetric signed byte range. It reverses the vertical axis, so that upward motion is positive on the wire. It then writes the packet into the queue at one byte per clock.

The read side works like the data register of a receive channel. A pop returns the oldest byte on the next clock. A receive-available flag stays high as long as the queue holds any byte. When the queue is full, further bytes are dropped without any indication. A pop from an empty queue returns zero.

Top module: `mouse_pkt_enc`

## Requirements
- R1: After reset, `rx_avail` is 0 and `rd_data` is 0x00.
- R2: The first byte of a packet is 0x87 with bit 2 cleared while the left button is down, bit 1 cleared for the middle button and bit 0 cleared for the right button. The other bits stay as in 0x87.
- R3: The second byte is the horizontal motion clamped to -127..+127 and sent as a two's-complement byte. For example, -128 becomes 0x81 and +300 becomes 0x7F.
- R4: The third byte is the negated vertical motion clamped to -127..+127. For example, -512 becomes 0x7F, +128 becomes 0x81 and +3 becomes 0xFD.
- R5: The fourth and fifth bytes of a packet are always 0x00.
- R6: The five bytes enter the queue in order, one per clock. The first byte is written on the clock edge after the edge that samples `evt_valid`, so `rx_avail` rises one cycle after the event.
- R7: An `evt_valid` strobe sampled while the bytes of an earlier packet are still being written is ignored and produces no bytes.
- R8: The queue holds 16 bytes. A byte written while 16 bytes are held is discarded, and the bytes already held are kept unchanged.
- R9: A pop while the queue is empty returns 0x00 on `rd_data` on the next cycle and leaves the queue empty.
- R10: A pop that removes a byte presents that byte on `rd_data` on the next cycle. `rx_avail` stays 1 after the pop if bytes remain and drops to 0 when the last byte is removed.
- R11: A byte write and a pop on the same clock both take effect. The full and empty decisions use the fill level from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | One-cycle pointer event strobe |
| evt_dx | input | MOT_W | Signed horizontal motion |
| evt_dy | input | MOT_W | Signed vertical motion |
| btn_left | input | 1 | Left button held |
| btn_mid | input | 1 | Middle button held |
| btn_right | input | 1 | Right button held |
| rd_pop | input | 1 | Read strobe that removes the oldest byte |
| rd_data | output | 8 | Byte returned by the last pop |
| rx_avail | output | 1 | Queue holds at least one byte |

## Verification
Events are applied with every button combination, so that each header bit is checked on its own. Motion values are chosen inside the clamp range, exactly at ±127, at -128, and well beyond the range, so that the saturation boundary and the two's-complement wrap can be told apart. A vertical value of -512 shows whether the negation overflows. Several packets are sent back to back with no pops, which separates dropped bytes from overwritten ones. Further sequences cover an event during a packet that is still being written, pops on an empty queue, and pops on every cycle while a packet is being written, which tests simultaneous write and read.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
  localparam int BYTE_W  = 8;
  localparam int PKT_LEN = 5;
  localparam logic [BYTE_W-1:0] HDR_BASE = 8'h87;
  localparam int LEFT_BIT  = 2;
  localparam int MID_BIT   = 1;
  localparam int RIGHT_BIT = 0;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/mpe_packer.sv
module mpe_packer
  import mpe_pkg::*;
#(
  parameter int MOT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_valid,
  input  logic [MOT_W-1:0] evt_dx,
  input  logic [MOT_W-1:0] evt_dy,
  input  logic             btn_left,
  input  logic             btn_mid,
  input  logic             btn_right,
  output logic             push_valid,
  output byte_t            push_data
);
  localparam int EXT_W = MOT_W + 1;
  localparam int IDX_W = $clog2(PKT_LEN + 1);
  localparam logic signed [EXT_W-1:0] POS_LIM = EXT_W'(127);
  localparam logic signed [EXT_W-1:0] NEG_LIM = -EXT_W'(127);

  function automatic byte_t clamp_byte(input logic signed [EXT_W-1:0] v);
    if (v > POS_LIM)      return 8'h7F;
    else if (v < NEG_LIM) return 8'h81;
    else                  return v[BYTE_W-1:0];
  endfunction

  logic signed [EXT_W-1:0] dx_ext, dy_neg;
  byte_t                   hdr;
  byte_t                   fresh [PKT_LEN];
  byte_t                   shreg [PKT_LEN];
  logic [IDX_W-1:0]        left_cnt;
  logic                    accept;

  always_comb begin
    dx_ext = $signed({evt_dx[MOT_W-1], evt_dx});
    dy_neg = -$signed({evt_dy[MOT_W-1], evt_dy});
    hdr = HDR_BASE;
    if (btn_left)  hdr[LEFT_BIT]  = 1'b0;
    if (btn_mid)   hdr[MID_BIT]   = 1'b0;
    if (btn_right) hdr[RIGHT_BIT] = 1'b0;
  end

  generate
    for (genvar i = 0; i < PKT_LEN; i++) begin : g_fresh
      if (i == 0)      begin : g_hdr  assign fresh[i] = hdr;                end
      else if (i == 1) begin : g_dx   assign fresh[i] = clamp_byte(dx_ext); end
      else if (i == 2) begin : g_dy   assign fresh[i] = clamp_byte(dy_neg); end
      else             begin : g_pad  assign fresh[i] = '0;                 end
    end
  endgenerate

  assign accept = evt_valid && (left_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      left_cnt <= '0;
    end else if (accept) begin
      left_cnt <= IDX_W'(PKT_LEN);
    end else if (left_cnt != '0) begin
      left_cnt <= left_cnt - 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < PKT_LEN; i++) begin : g_shift
      always_ff @(posedge clk) begin
        if (rst) begin
          shreg[i] <= '0;
        end else if (accept) begin
          shreg[i] <= fresh[i];
        end else if (left_cnt != '0) begin
          if (i == PKT_LEN - 1) shreg[i] <= '0;
          else                  shreg[i] <= shreg[(i + 1) % PKT_LEN];
        end
      end
    end
  endgenerate

  assign push_valid = (left_cnt != '0);
  assign push_data  = shreg[0];

  a_r6_packet_len: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && left_cnt == '0) |=> (left_cnt == IDX_W'(PKT_LEN)));
  a_r7_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    (left_cnt != '0) |=> (left_cnt == $past(left_cnt) - 1'b1));
  a_r5_tail_zero: assert property (@(posedge clk) disable iff (rst)
    (left_cnt == IDX_W'(2) || left_cnt == IDX_W'(1)) |-> (push_data == '0));
endmodule

// File: rtl/mpe_queue.sv
module mpe_queue
  import mpe_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  push_valid,
  input  byte_t push_data,
  input  logic  pop,
  output byte_t rd_data,
  output logic  not_empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  byte_t            mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] fill;
  logic             push_ok, pop_ok;

  assign push_ok = push_valid && (fill != CNT_W'(DEPTH));
  assign pop_ok  = pop && (fill != '0);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (pop_ok) begin
      rd_data <= mem[rptr];
    end else if (pop) begin
      rd_data <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assign not_empty = (fill != '0);

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    fill <= CNT_W'(DEPTH));
  a_r8_full_hold: assert property (@(posedge clk) disable iff (rst)
    (fill == CNT_W'(DEPTH) && push_valid && !pop) |=> (fill == CNT_W'(DEPTH)));
  a_r9_empty_pop_zero: assert property (@(posedge clk) disable iff (rst)
    (pop && fill == '0) |=> (rd_data == '0));
  a_r10_avail_kept: assert property (@(posedge clk) disable iff (rst)
    (pop && fill > CNT_W'(1)) |=> not_empty);
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
  import mpe_pkg::*;
#(
  parameter int MOT_W = 10,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_valid,
  input  logic [MOT_W-1:0] evt_dx,
  input  logic [MOT_W-1:0] evt_dy,
  input  logic             btn_left,
  input  logic             btn_mid,
  input  logic             btn_right,
  input  logic             rd_pop,
  output logic [7:0]       rd_data,
  output logic             rx_avail
);
  logic  pk_valid;
  byte_t pk_data;

  mpe_packer #(.MOT_W(MOT_W)) u_pack (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_dx(evt_dx),
    .evt_dy(evt_dy), .btn_left(btn_left), .btn_mid(btn_mid),
    .btn_right(btn_right), .push_valid(pk_valid), .push_data(pk_data)
  );

  mpe_queue #(.DEPTH(DEPTH)) u_q (
    .clk(clk), .rst(rst), .push_valid(pk_valid), .push_data(pk_data),
    .pop(rd_pop), .rd_data(rd_data), .not_empty(rx_avail)
  );

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!rx_avail && rd_data == 8'h00));
endmodule

// File: tb/sim_mouse_pkt_enc.sv
module sim_mouse_pkt_enc;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evt_valid = 1'b0;
  logic [9:0] evt_dx = '0, evt_dy = '0;
  logic btn_left = 1'b0, btn_mid = 1'b0, btn_right = 1'b0;
  logic rd_pop = 1'b0;
  logic [7:0] rd_data;
  logic rx_avail;

  int n_vec = 0, n_bad = 0;
  bit finished = 1'b0;

  logic [7:0] m_q[$];
  logic [7:0] m_pend[$];
  logic [7:0] m_rd = 8'h00;

  always #10 clk = ~clk;

  mouse_pkt_enc u0 (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_dx(evt_dx),
    .evt_dy(evt_dy), .btn_left(btn_left), .btn_mid(btn_mid),
    .btn_right(btn_right), .rd_pop(rd_pop), .rd_data(rd_data),
    .rx_avail(rx_avail)
  );

  function automatic logic [7:0] clampb(input int v);
    if (v > 127)  return 8'h7F;
    if (v < -127) return 8'h81;
    return 8'(v);
  endfunction

  task automatic check(input string tag, input logic [7:0] a, input logic [7:0] e);
    n_vec++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, a, e);
    end
  endtask

  // one clock: drive, update model at the edge, compare mid-low phase
  task automatic tick(input bit ev, input int dx, input int dy,
                      input bit l, input bit m, input bit r,
                      input bit pop, input string tag);
    logic [7:0] hdr;
    int pre;
    bit busy;
    logic [7:0] b;
    evt_valid = ev; evt_dx = 10'(dx); evt_dy = 10'(dy);
    btn_left = l; btn_mid = m; btn_right = r; rd_pop = pop;
    @(posedge clk);
    pre  = m_q.size();
    busy = (m_pend.size() != 0);
    if (pop) begin
      if (pre > 0) m_rd = m_q.pop_front();
      else         m_rd = 8'h00;
    end
    if (busy) begin
      b = m_pend.pop_front();
      if (pre < 16) m_q.push_back(b);
    end
    if (ev && !busy) begin
      hdr = 8'h87;
      if (l) hdr[2] = 1'b0;
      if (m) hdr[1] = 1'b0;
      if (r) hdr[0] = 1'b0;
      m_pend.push_back(hdr);
      m_pend.push_back(clampb(dx));
      m_pend.push_back(clampb(-dy));
      m_pend.push_back(8'h00);
      m_pend.push_back(8'h00);
    end
    @(negedge clk);
    check({tag, " rd_data"}, rd_data, m_rd);
    check({tag, " rx_avail"}, {7'b0, rx_avail}, {7'b0, m_q.size() != 0});
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic drain(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0, 1, tag);
  endtask

  task automatic packet(input int dx, input int dy, input bit l, input bit m,
                        input bit r, input string tag);
    tick(1, dx, dy, l, m, r, 0, tag);
    idle(5, tag);
    drain(5, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    @(negedge clk);
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 rx_avail", {7'b0, rx_avail}, 8'h00);
    // R2 / R3 / R4 / R5 / R6: basic packets, all button combinations
    for (int k = 0; k < 8; k++)
      packet(5 + k, 3 - k, k[2], k[1], k[0], "R2 buttons");
    packet(300, -512, 1, 0, 0, "R3 R4 beyond range");
    packet(-128, 128, 0, 1, 0, "R3 R4 minus 128");
    packet(-300, -128, 0, 0, 1, "R3 R4 negative sat");
    packet(127, -127, 0, 0, 0, "R3 R4 at limit");
    packet(-127, 127, 1, 1, 1, "R5 R6 at limit");
    // R6: rx_avail rises one cycle after event
    tick(1, 1, 1, 0, 0, 0, 0, "R6 event");
    tick(0, 0, 0, 0, 0, 0, 0, "R6 first write");
    check("R6 avail after one cycle", {7'b0, rx_avail}, 8'h01);
    idle(4, "R6 tail");
    drain(5, "R6 drain");
    // R7: events during an ongoing packet are ignored
    tick(1, 10, 10, 0, 0, 0, 0, "R7 start");
    for (int i = 0; i < 5; i++) tick(1, 99, 99, 1, 1, 1, 0, "R7 busy event");
    idle(2, "R7 settle");
    drain(6, "R7 drain");
    // R8: overflow, four packets with no pops
    for (int p = 0; p < 4; p++) begin
      tick(1, p, p, p[0], 0, 0, 0, "R8 fill");
      idle(5, "R8 fill");
    end
    drain(16, "R8 R10 drain");
    // R9: pops on empty queue
    drain(3, "R9 empty pop");
    // R11: pop every cycle while writing
    tick(1, 40, -40, 0, 1, 1, 1, "R11 event");
    drain(8, "R11 concurrent");
    idle(3, "R11 end");
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule